// File: doc/BRIEF.md
# Single-Channel Packing DMA Engine

This block moves a programmed number of bytes from a source pointer to a destination pointer over a synchronous bus master port with a 24-bit byte address, a 16-bit data path and two byte-lane strobes. The channel is armed by a one-cycle start pulse that loads both pointers, a byte counter, a direction code and a unit size (byte or word). Either pointer may be odd or even. The engine splits or merges bytes as needed, so a word unit always costs the fewest cycles its alignment permits: two, three or four bus cycles.

When one side is a peripheral, that side's pointer stays fixed and each transfer unit waits for an external request line. The unit is acknowledged with a one-cycle pulse. The engine never starts a new bus cycle while a higher-priority requester or the halt line is asserting. A retry response repeats the identical cycle. A bus error stops the channel and latches an error flag. When the counter reaches zero, a one-cycle done pulse is emitted and a completion interrupt is raised.

Top module: `dma_engine`

## Requirements
- R1: After synchronous reset, bus_cyc, busy, irq, err, xack and xdone are all 0.
- R2: In word mode with even source and even destination, each unit is exactly two bus cycles: one word read and then one word write, both with bus_be = 2'b11.
- R3: In word mode with an odd source and an even destination, each unit is three cycles: two byte reads packed into one word write.
- R4: In word mode with an even source and an odd destination, each unit is three cycles: one word read unpacked into two byte writes.
- R5: In word mode with both addresses odd, each unit is four cycles: two byte reads and then two byte writes.
- R6: A byte at an even address uses bus_be = 2'b10 and data bits [15:8]. A byte at an odd address uses bus_be = 2'b01 and bits [7:0]. A word cycle (2'b11) occurs only at an even address. In byte mode each byte costs one read and one write.
- R7: The counter holds bytes and drops by the width of each completed write. In word mode an odd count ends with one byte unit. When the count reaches zero, xdone pulses for exactly one cycle, busy falls and irq goes high until the next start. A start with a zero count gives the done pulse and irq with no bus cycle.
- R8: cfg_dir 0 is memory to memory, 1 is memory to peripheral and 2 is peripheral to memory. The peripheral-side pointer never moves. Memory pointers advance by the bytes each cycle moves. Bytes arrive in source order, and no memory byte outside the destination range changes.
- R9: In modes 1 and 2, a unit begins only while xreq is high, and xack pulses once per unit.
- R10: A bus_err response ends the channel: busy falls, err rises, irq and xdone stay low, and no further cycle is issued. The next start clears err.
- R11: A bus_retry response causes the same cycle (address, strobes, direction) to be issued again, without any effect on the count or the data.
- R12: No new bus cycle begins while bus_halt or hp_req is high. A transfer resumes correctly after they drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and arm the channel (ignored while busy) |
| cfg_dir | input | 2 | Direction code (0 mem-mem, 1 mem-periph, 2 periph-mem) |
| cfg_word | input | 1 | 1 selects word units, 0 byte units |
| cfg_src | input | 24 | Source start address |
| cfg_dst | input | 24 | Destination start address |
| cfg_count | input | 16 | Byte count |
| xreq | input | 1 | External transfer request |
| xack | output | 1 | One-cycle pulse when a requested unit begins |
| xdone | output | 1 | One-cycle pulse when the count reaches zero |
| irq | output | 1 | Completion interrupt request |
| err | output | 1 | Bus error flag |
| busy | output | 1 | Channel active |
| hp_req | input | 1 | Higher-priority requester holds the bus |
| bus_cyc | output | 1 | Bus cycle request, held until a response |
| bus_we | output | 1 | 1 for write cycles |
| bus_addr | output | 24 | Byte address |
| bus_be | output | 2 | Byte-lane strobes (bit 1 upper, even byte) |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Cycle completed |
| bus_err | input | 1 | Cycle failed |
| bus_retry | input | 1 | Repeat the cycle |
| bus_halt | input | 1 | Stall before the next cycle |

## Verification
The hardest case to reach is a retry or an arbitration stall that lands in the middle of a split unit. It occurs between the first and second byte of a packed read or an unpacked write, where the partial word must survive. The bench drives retries at random, toggles hp_req at random and opens a halt window in the middle of transfers, using odd-aligned word transfers. The rerun cycle must match the retried one field for field, and the final byte image must match a model built from the source bytes.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    DIR_M2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_P2M = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          fixed,
  input  logic [1:0]    step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv && !fixed) ptr <= ptr + AW'(step);
  end

  // R8
  fixed_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fixed && !load) |=> $stable(ptr));
endmodule

// File: rtl/dma_lane.sv
module dma_lane
  import dma_eng_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic              rd_lsb,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              wr_lsb,
  output logic [DATA_W-1:0] wr_lanes,
  output logic [LANES-1:0]  wr_be
);
  always_comb begin
    rd_byte  = rd_lsb ? rdata[BYTE_W-1:0] : rdata[DATA_W-1:BYTE_W];
    wr_lanes = {wr_byte, wr_byte};
    wr_be    = wr_lsb ? 2'b01 : 2'b10;
    // R6
    lane_onehot_chk: assert ($onehot(wr_be));
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_eng_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cfg_dir,
  input  logic              cfg_word,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [CW-1:0]     cfg_count,
  input  logic              xreq,
  output logic              xack,
  output logic              xdone,
  output logic              irq,
  output logic              err,
  output logic              busy,
  input  logic              hp_req,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic              bus_retry,
  input  logic              bus_halt
);
  st_e               st;
  dir_e              dir_q;
  logic              word_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] hold;
  logic              in_wr, k, unit_open, unit_word, rd_split, wr_split;
  logic [AW-1:0]     src_ptr, dst_ptr, cur_addr;
  logic              u_word, r_split, w_split, cur_word, periph, go, acked, load;
  logic [1:0]        step;
  logic [CW-1:0]     cnt_next;
  logic [BYTE_W-1:0] rd_byte, wr_byte;
  logic [DATA_W-1:0] lane_wdata;
  logic [LANES-1:0]  lane_be;

  assign busy   = (st != ST_IDLE);
  assign periph = (dir_q != DIR_M2M);
  assign load   = start && (st == ST_IDLE);
  assign acked  = (st == ST_WAIT) && bus_ack && !bus_err && !bus_retry;

  always_comb begin
    u_word   = unit_open ? unit_word : (word_q && cnt > CW'(1));
    r_split  = unit_open ? rd_split  : (u_word && src_ptr[0]);
    w_split  = unit_open ? wr_split  : (u_word && dst_ptr[0]);
    cur_addr = in_wr ? dst_ptr : src_ptr;
    cur_word = in_wr ? (u_word && !w_split) : (u_word && !r_split);
    step     = cur_word ? 2'd2 : 2'd1;
    cnt_next = cnt - CW'(step);
    wr_byte  = k ? hold[BYTE_W-1:0] : hold[DATA_W-1:BYTE_W];
    go       = (st == ST_ISSUE) && !bus_halt && !hp_req && (!periph || unit_open || xreq);
  end

  dma_ptr #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(load), .load_val(cfg_src),
    .adv(acked && !in_wr), .fixed(dir_q == DIR_P2M), .step(step), .ptr(src_ptr));

  dma_ptr #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(load), .load_val(cfg_dst),
    .adv(acked && in_wr), .fixed(dir_q == DIR_M2P), .step(step), .ptr(dst_ptr));

  dma_lane u_lane (
    .rdata(bus_rdata), .rd_lsb(bus_addr[0]), .rd_byte(rd_byte),
    .wr_byte(wr_byte), .wr_lsb(cur_addr[0]), .wr_lanes(lane_wdata), .wr_be(lane_be));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; dir_q <= DIR_M2M; word_q <= 1'b0; cnt <= '0; hold <= '0;
      in_wr <= 1'b0; k <= 1'b0; unit_open <= 1'b0; unit_word <= 1'b0;
      rd_split <= 1'b0; wr_split <= 1'b0;
      xack <= 1'b0; xdone <= 1'b0; irq <= 1'b0; err <= 1'b0;
      bus_cyc <= 1'b0; bus_we <= 1'b0; bus_addr <= '0; bus_be <= '0; bus_wdata <= '0;
    end else begin
      xack  <= 1'b0;
      xdone <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          dir_q <= dir_e'(cfg_dir); word_q <= cfg_word; cnt <= cfg_count;
          err <= 1'b0; irq <= 1'b0; in_wr <= 1'b0; k <= 1'b0; unit_open <= 1'b0;
          if (cfg_count == '0) begin
            xdone <= 1'b1;
            irq   <= 1'b1;
          end else begin
            st <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (go) begin
          bus_cyc   <= 1'b1;
          bus_we    <= in_wr;
          bus_addr  <= cur_addr;
          bus_be    <= cur_word ? 2'b11 : lane_be;
          bus_wdata <= cur_word ? hold : lane_wdata;
          if (!unit_open) begin
            unit_open <= 1'b1;
            unit_word <= u_word;
            rd_split  <= r_split;
            wr_split  <= w_split;
            xack      <= periph;
          end
          st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bus_err) begin
            bus_cyc <= 1'b0;
            err     <= 1'b1;
            st      <= ST_IDLE;
          end else if (bus_retry) begin
            bus_cyc <= 1'b0;
            st      <= ST_ISSUE;
          end else if (bus_ack) begin
            bus_cyc <= 1'b0;
            st      <= ST_ISSUE;
            if (!in_wr) begin
              if (cur_word)  hold <= bus_rdata;
              else if (k)    hold[BYTE_W-1:0] <= rd_byte;
              else           hold[DATA_W-1:BYTE_W] <= rd_byte;
              if (r_split && !k) k <= 1'b1;
              else begin k <= 1'b0; in_wr <= 1'b1; end
            end else begin
              cnt <= cnt_next;
              if (w_split && !k) k <= 1'b1;
              else begin
                k <= 1'b0; in_wr <= 1'b0; unit_open <= 1'b0;
                if (cnt_next == '0) begin
                  xdone <= 1'b1;
                  irq   <= 1'b1;
                  st    <= ST_IDLE;
                end
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  cyc_needs_busy_chk: assert property (@(posedge clk) disable iff (rst) bus_cyc |-> busy);
  // R2
  word_even_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_be == 2'b11) |-> !bus_addr[0]);
  // R6
  upper_lane_even_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_be == 2'b10) |-> !bus_addr[0]);
  // R6
  lower_lane_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_be == 2'b01) |-> bus_addr[0]);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) xdone |=> !xdone);
  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_err) |=> (!busy && err && !bus_cyc && !irq));
  // R11
  retry_same_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_retry && !bus_err) |=> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_we)));
  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_halt && !bus_cyc) |=> !bus_cyc);
  // R12
  hp_yield_chk: assert property (@(posedge clk) disable iff (rst)
    (hp_req && !bus_cyc) |=> !bus_cyc);
  // R11
  hold_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ack && !bus_err && !bus_retry) |=> (bus_cyc && $stable(bus_addr)));
endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, cfg_word = 0, xreq = 0, hp_req = 0;
  logic [1:0] cfg_dir = 0;
  logic [23:0] cfg_src = 0, cfg_dst = 0;
  logic [15:0] cfg_count = 0;
  logic xack, xdone, irq, err, busy, bus_cyc, bus_we;
  logic [23:0] bus_addr;
  logic [1:0] bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = 0;
  logic bus_ack = 0, bus_err = 0, bus_retry = 0, bus_halt = 0;

  always #5 clk = ~clk;

  dma_engine uut (.*);

  int total = 0, fails = 0;
  logic [7:0] mem [512];
  logic [7:0] orig [512];
  logic [7:0] plog [64];
  int pl_n, ps, acked, done_cnt, xack_cnt, rises;
  int err_at = -1, retry_pct = 0, halt_left = 0;
  int blk_viol, rt_viol, lane_viol;
  bit hp_rand = 0, cyc_prev = 0, blk_prev = 0, rt_pend = 0, rt_we;
  logic [23:0] rt_addr;
  logic [1:0] rt_be;

  function automatic logic [7:0] sv(input int n);
    return 8'(n * 7 + 3) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave, arbitration driver and monitors
  initial begin
    forever begin
      @(negedge clk);
      if (hp_rand) hp_req = ($urandom_range(3) == 0);
      if (halt_left > 0) begin bus_halt = 1; halt_left--; end else bus_halt = 0;
      if (bus_cyc && !cyc_prev) begin
        rises++;
        if (blk_prev) blk_viol++;
        if (rt_pend) begin
          if (bus_addr != rt_addr || bus_be != rt_be || bus_we != rt_we) rt_viol++;
          rt_pend = 0;
        end
      end
      if (bus_cyc && ((bus_be == 2'b01 && !bus_addr[0]) || (bus_be != 2'b01 && bus_addr[0]) ||
                      bus_be == 2'b00)) lane_viol++;
      if (xdone) done_cnt++;
      if (xack) xack_cnt++;
      cyc_prev = bus_cyc;
      blk_prev = bus_halt || hp_req;
      if (bus_ack || bus_err || bus_retry) begin
        bus_ack = 0; bus_err = 0; bus_retry = 0;
      end else if (bus_cyc) begin
        if (acked == err_at) bus_err = 1;
        else if (int'($urandom_range(99)) < retry_pct) begin
          bus_retry = 1; rt_pend = 1; rt_addr = bus_addr; rt_be = bus_be; rt_we = bus_we;
        end else begin
          if (bus_addr[11:8] == 4'hF) begin
            if (bus_we) begin
              if (bus_be[1]) begin plog[pl_n] = bus_wdata[15:8]; pl_n++; end
              if (bus_be[0]) begin plog[pl_n] = bus_wdata[7:0]; pl_n++; end
            end else begin
              bus_rdata = 16'h0;
              if (bus_be[1]) begin bus_rdata[15:8] = sv(ps); ps++; end
              if (bus_be[0]) begin bus_rdata[7:0] = sv(ps); ps++; end
            end
          end else begin
            if (bus_we) begin
              if (bus_be[1]) mem[{bus_addr[8:1], 1'b0}] = bus_wdata[15:8];
              if (bus_be[0]) mem[{bus_addr[8:1], 1'b1}] = bus_wdata[7:0];
            end else
              bus_rdata = {mem[{bus_addr[8:1], 1'b0}], mem[{bus_addr[8:1], 1'b1}]};
          end
          bus_ack = 1;
          acked++;
        end
      end
    end
  end

  task automatic arm(input int dir, input bit word, input int src, input int dst, input int n);
    for (int i = 0; i < 512; i++) begin mem[i] = 8'($urandom); orig[i] = mem[i]; end
    ps = 0; pl_n = 0; acked = 0; done_cnt = 0; xack_cnt = 0;
    blk_viol = 0; rt_viol = 0; lane_viol = 0;
    @(negedge clk);
    cfg_dir = 2'(dir); cfg_word = word; cfg_src = 24'(src); cfg_dst = 24'(dst);
    cfg_count = 16'(n); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_wait();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic verify(input int dir, input bit word, input int src, input int dst,
                        input int n, input string creq);
    int nw, nb, exp_cyc, bad, first;
    nw = word ? n / 2 : 0;
    nb = word ? n % 2 : n;
    exp_cyc = nw * (2 + (src & 1) + (dst & 1)) + nb * 2;
    chk(acked == exp_cyc, creq, acked, exp_cyc);
    bad = 0; first = -1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e, a;
      e = (dir == 2) ? sv(i) : orig[src + i];
      a = (dir == 1) ? plog[i] : mem[dst + i];
      if (a != e) begin bad++; if (first < 0) first = i; end
    end
    chk(bad == 0, "R8 data order", bad, 0);
    if (dir == 1) chk(pl_n == n, "R8 periph bytes", pl_n, n);
    else begin
      chk(mem[dst - 1] == orig[dst - 1] && mem[dst + n] == orig[dst + n],
          "R8 guard bytes", int'(mem[dst + n]), int'(orig[dst + n]));
    end
    chk(done_cnt == 1 && irq && !busy && !err, "R7 completion", done_cnt, 1);
    chk(lane_viol == 0, "R6 lanes", lane_viol, 0);
    chk(rt_viol == 0, "R11 retry same cycle", rt_viol, 0);
    chk(blk_viol == 0, "R12 no cycle while blocked", blk_viol, 0);
    if (dir != 0) chk(xack_cnt == nw + nb, "R9 xack per unit", xack_cnt, nw + nb);
  endtask

  task automatic run(input int dir, input bit word, input int src, input int dst,
                     input int n, input string creq);
    arm(dir, word, src, dst, n);
    finish_wait();
    verify(dir, word, src, dst, n, creq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_cyc && !busy && !irq && !err && !xack && !xdone, "R1 reset", int'(busy), 0);
    rst = 0;
    xreq = 1;
    void'($urandom(32'd1234));
    // directed alignment cases
    run(0, 1, 16'h010, 16'h120, 8, "R2 even/even cycles");
    run(0, 1, 16'h011, 16'h120, 8, "R3 odd/even cycles");
    run(0, 1, 16'h010, 16'h121, 8, "R4 even/odd cycles");
    run(0, 1, 16'h011, 16'h121, 8, "R5 odd/odd cycles");
    run(0, 0, 16'h013, 16'h140, 5, "R6 byte mode cycles");
    run(0, 1, 16'h020, 16'h150, 7, "R7 odd count tail");
    run(1, 1, 16'h031, 16'hF01, 6, "R8 mem to periph cycles");
    run(2, 1, 16'hF00, 16'h133, 9, "R8 periph to mem cycles");
    // zero count
    arm(0, 1, 16'h010, 16'h120, 0);
    repeat (3) @(negedge clk);
    chk(acked == 0 && done_cnt == 1 && irq && !busy, "R7 zero count", acked, 0);
    // request gating
    xreq = 0;
    rises = 0;
    arm(2, 1, 16'hF00, 16'h160, 4);
    repeat (20) @(negedge clk);
    chk(rises == 0, "R9 waits for xreq", rises, 0);
    xreq = 1;
    finish_wait();
    verify(2, 1, 16'hF00, 16'h160, 4, "R9 gated cycles");
    // halt window mid transfer
    arm(0, 1, 16'h011, 16'h121, 12);
    repeat (9) @(negedge clk);
    @(posedge clk); halt_left = 30;
    repeat (5) @(negedge clk);
    rises = 0;
    repeat (20) @(negedge clk);
    chk(rises == 0, "R12 halt stalls", rises, 0);
    finish_wait();
    verify(0, 1, 16'h011, 16'h121, 12, "R12 after halt cycles");
    // bus error
    err_at = 3;
    arm(0, 1, 16'h010, 16'h120, 10);
    finish_wait();
    rises = 0;
    repeat (20) @(negedge clk);
    chk(err && !busy && !irq && done_cnt == 0, "R10 abort flags", int'(err), 1);
    chk(acked == 3 && rises == 0, "R10 no more cycles", acked + rises, 3);
    err_at = -1;
    arm(0, 0, 16'h010, 16'h120, 2);
    chk(!err, "R10 start clears err", int'(err), 0);
    finish_wait();
    verify(0, 0, 16'h010, 16'h120, 2, "R10 after error cycles");
    // random mix with retries and priority requester
    retry_pct = 20;
    @(posedge clk); hp_rand = 1;
    for (int r = 0; r < 24; r++) begin
      int dir, s, d, n;
      bit w;
      dir = $urandom_range(2);
      w = 1'($urandom_range(1));
      n = $urandom_range(1, 40);
      s = (dir == 2) ? (16'hF00 + $urandom_range(1)) : $urandom_range(1, 200);
      d = (dir == 1) ? (16'hF00 + $urandom_range(1)) : $urandom_range(16'h101, 16'h1C0);
      run(dir, w, s, d, n, "R11 random cycles");
    end
    @(posedge clk); hp_rand = 0; hp_req = 0;
    retry_pct = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule